// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register set of a simple serial port. A processor reaches it through a word-wide read/write port addressed by a small word offset. The block keeps one received byte in a holding register, keeps a status flag word, a control word and an interrupt identification word, and drives two interrupt request lines (receive and transmit) toward an interrupt controller. The serial shifter, baud timing and any queueing sit outside. Received bytes arrive on a valid/ready byte input. Transmitted bytes leave as a one-cycle strobe carrying the byte.

Reading the data offset consumes the held byte. In one step it empties the holding register, removes all receive interrupt state and marks the receiver empty. The transmit interrupt does not follow any data movement. It is raised or dropped only by the transmit-interrupt-enable bit each time the control word is written. Offsets that the block does not implement read as zero and ignore writes.

Register offsets (word index): 0 data, 1 flag, 2 control, 3 identification. Read data appears on `bus_rdata` one cycle after the read access.

Top module: `serial_reg_front`

## Requirements
- R1: After reset the flag word reads 0x80 (transmit-empty bit 7 set, every other bit clear, receive-empty bit 4 clear), the data offset reads 0, both interrupt lines are low and no transmit strobe is issued.
- R2: Flag bit 4 (receive-empty) is cleared on the cycle after a byte is captured and set on the cycle after the data offset is read. Bit 7 stays set.
- R3: `rx_ready` is high exactly when no receive interrupt is pending and the holding register holds the value zero. A byte offered while `rx_ready` is low is ignored.
- R4: Capturing a byte (`rx_valid` and `rx_ready` at a clock edge) loads it into the holding register. On the next cycle `irq_rx` is high and identification bit 1 is set.
- R5: A read of the data offset returns the held byte zero-extended. From the next cycle the holding register is zero, `irq_rx` is low, identification bit 1 is clear and receive-empty is set.
- R6: A write to the data offset produces `tx_valid` for exactly one cycle, on the cycle after the write, with `tx_data` equal to bits 7:0 of the written word.
- R7: A write to the control offset stores the whole word (read back unchanged). If bit 5 (transmit-interrupt-enable) of the word is set, `irq_tx` and identification bit 2 become 1 on the next cycle. If bit 5 is clear, both become 0. `irq_tx` changes at no other time.
- R8: A write to the identification offset replaces the whole identification word and leaves both interrupt lines unchanged.
- R9: Reads of offsets 4 and above return zero, and writes to them change nothing. Writes to the flag offset are ignored.
- R10: `bus_rdata` carries the selected register one cycle after a read access and is zero on the cycle after any non-read cycle.
- R11: If a byte is captured in the same cycle as a read of the data offset, the read returns the previous holding value and the capture wins: the new byte is held, `irq_rx` is high and receive-empty is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Holding register can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | BYTE_W | Byte to transmit |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit data word, 8-bit bytes and a 4-bit offset. This gives twelve unmapped offsets for the ignore checks and leaves the upper 24 data bits free to show zero extension of the held byte and whole-word storage of the control and identification registers. Directed sequences cover reset values, blocked offers while a byte is pending, capture colliding with a data read, and both settings of the enable bit. A long random run then mixes every offset with random receive offers.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // word offsets of the implemented registers
    localparam int OFS_DATA  = 0;
    localparam int OFS_FLAG  = 1;
    localparam int OFS_CTRL  = 2;
    localparam int OFS_IDENT = 3;

    // bit positions that software decodes
    localparam int FLAG_RXE_BIT  = 4;
    localparam int FLAG_TXE_BIT  = 7;
    localparam int IDENT_RX_BIT  = 1;
    localparam int IDENT_TX_BIT  = 2;
    localparam int CTRL_TXIE_BIT = 5;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_FLAG  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_IDENT = 3'd4,
        SEL_ZERO  = 3'd5
    } srf_sel_e;

    typedef struct packed {
        logic     rd_data;
        logic     wr_data;
        logic     wr_ctrl;
        logic     wr_ident;
        srf_sel_e rd_sel;
    } srf_access_t;

    function automatic logic [2:0] sel_code(input srf_sel_e s);
        return 3'(s);
    endfunction

endpackage

// File: rtl/srf_decode.sv
module srf_decode
    import srf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output srf_access_t       acc
);

    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFS_IDENT);

    logic rd, wr;

    always_comb begin
        rd = bus_en && !bus_we;
        wr = bus_en && bus_we;

        acc          = '0;
        acc.rd_sel   = SEL_NONE;
        acc.rd_data  = rd && (bus_addr == A_DATA);
        acc.wr_data  = wr && (bus_addr == A_DATA);
        acc.wr_ctrl  = wr && (bus_addr == A_CTRL);
        acc.wr_ident = wr && (bus_addr == A_IDENT);

        if (rd) begin
            unique case (bus_addr)
                A_DATA:  acc.rd_sel = SEL_DATA;
                A_FLAG:  acc.rd_sel = SEL_FLAG;
                A_CTRL:  acc.rd_sel = SEL_CTRL;
                A_IDENT: acc.rd_sel = SEL_IDENT;
                default: acc.rd_sel = SEL_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/srf_rx_path.sv
module srf_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              consume,
    output logic              rx_ready,
    output logic              capture,
    output logic [BYTE_W-1:0] hold_q,
    output logic              pend_q,
    output logic              rxe_q
);

    // emptiness is judged by the held value, as the register map defines it
    assign rx_ready = !pend_q && (hold_q == '0);
    assign capture  = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
            rxe_q  <= 1'b0;
        end else if (capture) begin
            hold_q <= rx_data;
            pend_q <= 1'b1;
            rxe_q  <= 1'b0;
        end else if (consume) begin
            hold_q <= '0;
            pend_q <= 1'b0;
            rxe_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/srf_tx_path.sv
module srf_tx_path
    import srf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              irq_tx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_data;
            if (wr_data) tx_data <= wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_tx <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
            irq_tx <= wdata[CTRL_TXIE_BIT];
        end
    end

endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
    import srf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq_rx,
    output logic              irq_tx
);

    localparam int PAD_W = DATA_W - BYTE_W;

    srf_access_t       acc;
    logic              capture;
    logic [BYTE_W-1:0] hold_q;
    logic              rxe_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ident_q;
    logic [DATA_W-1:0] flag_w;
    logic [DATA_W-1:0] ident_n;
    logic [DATA_W-1:0] rd_mux;

    srf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    srf_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .consume  (acc.rd_data),
        .rx_ready (rx_ready),
        .capture  (capture),
        .hold_q   (hold_q),
        .pend_q   (irq_rx),
        .rxe_q    (rxe_q)
    );

    srf_tx_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (acc.wr_data),
        .wr_ctrl  (acc.wr_ctrl),
        .wdata    (bus_wdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .ctrl_q   (ctrl_q),
        .irq_tx   (irq_tx)
    );

    // flag word: transmit side always reports empty
    always_comb begin
        flag_w               = '0;
        flag_w[FLAG_TXE_BIT] = 1'b1;
        flag_w[FLAG_RXE_BIT] = rxe_q;
    end

    // identification word: whole-word write, then event bits on top
    always_comb begin
        ident_n = ident_q;
        if (acc.wr_ident) ident_n = bus_wdata;
        if (acc.wr_ctrl)  ident_n[IDENT_TX_BIT] = bus_wdata[CTRL_TXIE_BIT];
        if (capture)          ident_n[IDENT_RX_BIT] = 1'b1;
        else if (acc.rd_data) ident_n[IDENT_RX_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ident_q <= '0;
        else     ident_q <= ident_n;
    end

    always_comb begin
        unique case (acc.rd_sel)
            SEL_DATA:  rd_mux = {{PAD_W{1'b0}}, hold_q};
            SEL_FLAG:  rd_mux = flag_w;
            SEL_CTRL:  rd_mux = ctrl_q;
            SEL_IDENT: rd_mux = ident_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/srf_checker.sv
module srf_checker
    import srf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic [BYTE_W-1:0] hold_q,
    input logic              rxe_q,
    input logic [DATA_W-1:0] ident_q
);

    logic take, dat_rd, dat_wr, ctl_wr;
    assign take   = rx_valid && rx_ready;
    assign dat_rd = bus_en && !bus_we && (bus_addr == ADDR_W'(OFS_DATA));
    assign dat_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_DATA));
    assign ctl_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

    assert_ready_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> (!irq_rx && hold_q == '0));

    assert_capture_raises_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> (irq_rx && ident_q[IDENT_RX_BIT]));

    assert_rxe_on_capture_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !rxe_q);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !take) |=> (!irq_rx && rxe_q && hold_q == '0 && !ident_q[IDENT_RX_BIT]));

    assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

    assert_tx_single_R6: assert property (@(posedge clk) disable iff (rst)
        !dat_wr |=> !tx_valid);

    assert_ctrl_irq_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (irq_tx == $past(bus_wdata[CTRL_TXIE_BIT])));

    assert_irqtx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(irq_tx));

endmodule

bind serial_reg_front srf_checker #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .hold_q    (hold_q),
    .rxe_q     (rxe_q),
    .ident_q   (ident_q)
);

// File: tb/sim_serial_reg_front.sv
`timescale 1ns/1ps
module sim_serial_reg_front;

    localparam int DW = 32;
    localparam int BW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rx_valid = 1'b0;
    logic [BW-1:0] rx_data = '0;
    logic          rx_ready, tx_valid, irq_rx, irq_tx;
    logic [BW-1:0] tx_data;

    always #4 clk = ~clk;

    serial_reg_front #(.DATA_W(DW), .BYTE_W(BW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state (value after the latest clock edge)
    logic [7:0]  m_hold;
    bit          m_pend, m_rxe, m_irqtx, m_txv;
    logic [7:0]  m_txd;
    logic [31:0] m_ctrl, m_ident, m_rdata;
    string       m_rtag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hold = 0; m_pend = 0; m_rxe = 0; m_irqtx = 0; m_txv = 0; m_txd = 0;
        m_ctrl = 0; m_ident = 0; m_rdata = 0; m_rtag = "R1";
    endtask

    function automatic logic [31:0] flag_val();
        return 32'h80 | (m_rxe ? 32'h10 : 32'h0);
    endfunction

    task automatic compare_all();
        chk(rx_ready === (!m_pend && m_hold == 0), "R3", "rx_ready", rx_ready, !m_pend && m_hold == 0);
        chk(irq_rx === m_pend, "R4", "irq_rx", irq_rx, m_pend);
        chk(irq_tx === m_irqtx, "R7", "irq_tx", irq_tx, m_irqtx);
        chk(tx_valid === m_txv, "R6", "tx_valid", tx_valid, m_txv);
        chk(tx_data === m_txd, "R6", "tx_data", tx_data, m_txd);
        chk(bus_rdata === m_rdata, m_rtag, "bus_rdata", bus_rdata, m_rdata);
    endtask

    // one cycle: check at negedge, drive, advance model across next posedge
    task automatic step(input bit en, input bit we, input int addr, input logic [31:0] wd,
                        input bit rv, input logic [7:0] rd);
        bit rdy, cap, rdd, wr;
        logic [31:0] nrd, nid;
        @(negedge clk);
        compare_all();
        bus_en = en; bus_we = we; bus_addr = AW'(addr); bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        rdy = !m_pend && m_hold == 0;
        cap = rv && rdy;
        rdd = en && !we && addr == 0;
        wr  = en && we;
        nrd = 0;
        if (en && !we) begin
            case (addr)
                0: begin nrd = {24'h0, m_hold}; m_rtag = "R5"; end
                1: begin nrd = flag_val();      m_rtag = "R2"; end
                2: begin nrd = m_ctrl;          m_rtag = "R7"; end
                3: begin nrd = m_ident;         m_rtag = "R8"; end
                default: begin nrd = 0;         m_rtag = "R9"; end
            endcase
        end else m_rtag = "R10";
        nid = m_ident;
        if (wr && addr == 3) nid = wd;
        if (wr && addr == 2) begin
            nid[2] = wd[5]; m_ctrl = wd; m_irqtx = wd[5];
        end
        if (cap) nid[1] = 1'b1; else if (rdd) nid[1] = 1'b0;
        m_ident = nid;
        m_rdata = nrd;
        m_txv = wr && addr == 0;
        if (m_txv) m_txd = wd[7:0];
        if (cap) begin m_hold = rd; m_pend = 1; m_rxe = 0; end
        else if (rdd) begin m_hold = 0; m_pend = 0; m_rxe = 1; end
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
    task automatic rd(input int a); step(1, 0, a, 0, 0, 0); endtask
    task automatic wr(input int a, input logic [31:0] d); step(1, 1, a, d, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk(bus_rdata === 0 && !irq_rx && !irq_tx && !tx_valid, "R1", "reset outputs",
            {bus_rdata[28:0], irq_rx, irq_tx, tx_valid}, 0);
        rd(1); idle();
        // R1: flag reads 0x80
        chk(bus_rdata === 32'h80, "R1", "flag after reset", bus_rdata, 32'h80);
        rd(0);
        // R3/R4: capture then blocked offer
        step(0, 0, 0, 0, 1, 8'h5A);
        step(0, 0, 0, 0, 1, 8'hC3);
        rd(1); rd(3);
        // R5: destructive read
        rd(0); rd(1); rd(0);
        // R7: enable set then clear
        wr(2, 32'hFFFF_FF20); rd(2); rd(3);
        wr(2, 32'h0000_00DF); rd(2); rd(3);
        // R8: identification write
        wr(3, 32'hDEAD_BEEF); rd(3); wr(3, 32'h0); rd(3);
        // R9: unmapped offsets and flag writes
        for (int a = 4; a < 16; a++) begin wr(a, 32'hFFFF_FFFF); rd(a); end
        wr(1, 32'h0); rd(1); rd(2);
        // R6: transmit strobes, back to back
        wr(0, 32'h1234_56A7); wr(0, 32'h0000_0001); idle();
        // R11: capture in the same cycle as a data read
        step(1, 0, 0, 0, 1, 8'h33);
        @(posedge clk); #2;
        chk(irq_rx === 1'b1 && rx_ready === 1'b0, "R11", "capture wins", {irq_rx, rx_ready}, 2'b10);
        rd(0); rd(0);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            int a;
            a = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 3);
            step($urandom_range(0, 2) != 0, $urandom_range(0, 1), a, $urandom,
                 $urandom_range(0, 1), 8'($urandom));
        end
        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule